// File: doc/BRIEF.md
# Legacy Region Attribute Address Router

This block sits on the memory request path and classifies every request against the legacy window that starts at 768 KB (0xC0000) and ends just below 1 MB (0x100000). The window is cut into thirteen segments. Each segment carries a read-enable and a write-enable attribute. A request that an attribute allows goes to main DRAM. A request that no attribute allows falls through, at its original address, to the downstream I/O hub port. Requests outside the window go to DRAM unchanged.

Two more rules sit on top of the attributes. Non-snooped traffic from PCI Express or from the I/O hub that targets 0xE0000–0xFFFFF always goes to DRAM. A request that the attributes send to the hub port and that also carries an implicit write-back is a hazard, and the block raises an error flag with it. Software loads all attribute bits through one 32-bit register write port. The routing result appears one cycle after a request is accepted, behind a valid/ready handshake.

Top module: `legacy_window_router`

## Requirements
- R1: After reset all thirteen segments are read- and write-disabled, `out_valid` is 0 and `req_ready` is 1, so a read of 0xF0000 issued before any attribute write goes to the hub port.
- R2: A read in the window goes to DRAM (`out_to_hub`=0) when its segment's read-enable bit is 1, and to the hub port (`out_to_hub`=1) when that bit is 0.
- R3: A write in the window goes to DRAM when its segment's write-enable bit is 1, and to the hub port when that bit is 0, whatever the read-enable bit is.
- R4: The attribute register sits at `cfg_addr`=0. Segment k owns bit 2k (read-enable) and bit 2k+1 (write-enable). Segments 0–11 are the 16 KB blocks at 0xC0000 + k·0x4000, which cover 0xC0000–0xEFFFF. Segment 12 is the single 64 KB block 0xF0000–0xFFFFF, with bits 24 and 25.
- R5: A request below 0xC0000 or at or above 0x100000 goes to DRAM, and its error flag is 0.
- R6: A request with `req_nosnoop`=1 and `req_src` other than 0 (0 = processor, 1 = PCI Express, 2 = I/O hub) that targets 0xE0000–0xFFFFF goes to DRAM whatever its attributes say. Non-snooped requests to 0xC0000–0xDFFFF, and non-snooped requests from the processor, follow the attributes.
- R7: `out_err` is 1 exactly when the request lies in the window, is routed to the hub port, and has `req_iwb`=1.
- R8: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1, with `req_ready` = !`out_valid` || `out_ready`. Its result shows on `out_valid`, `out_to_hub` and `out_err` after that edge, and stays unchanged while `out_ready` is 0.
- R9: An attribute write takes effect for requests accepted on later edges. A request accepted on the same edge as the write uses the old attributes.
- R10: Writes to any `cfg_addr` other than 0 change no attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Attribute register write strobe |
| cfg_addr | input | CFG_AW | Register offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | 2 | Originator: 0 processor, 1 PCI Express, 2 I/O hub |
| req_nosnoop | input | 1 | Request is non-snooped |
| req_iwb | input | 1 | Request carries an implicit write-back |
| out_valid | output | 1 | Routing result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_to_hub | output | 1 | 1 = I/O hub port, 0 = DRAM |
| out_err | output | 1 | Hazardous implicit write-back |

## Verification
A wrong attribute bit, or a segment index computed wrongly, shows up as an inverted `out_to_hub` on the first request that reaches the affected segment, one cycle after that request is accepted. Each mapping test therefore sets one attribute pattern and then probes both the segment it enables and a neighbour it leaves off. A corrupted result register shows up during a stall as an output that changes while `out_ready` is low. A timing fault between attribute writes and requests shows up only when a write and a request land on the same edge, so that case is driven on its own.

// File: rtl/legacy_window_router.sv
module legacy_window_router #(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_src,
  input  logic              req_nosnoop,
  input  logic              req_iwb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_to_hub,
  output logic              out_err
);
  localparam int NSEG   = 13;
  localparam int ATTR_W = 2 * NSEG;

  logic [ATTR_W-1:0] attr;
  logic [3:0]        seg;
  logic [1:0]        seg_bits;
  logic              in_win, bypass, allowed, to_hub, accept;

  assign in_win   = (req_addr[ADDR_W-1:18] == (ADDR_W-18)'(3));
  assign seg      = (req_addr[17:16] == 2'b11) ? 4'd12 : req_addr[17:14];
  assign seg_bits = attr[{seg, 1'b0} +: 2];
  assign bypass   = req_nosnoop && (req_src != 2'd0) && req_addr[17];
  assign allowed  = req_write ? seg_bits[1] : seg_bits[0];
  assign to_hub   = in_win && !bypass && !allowed;

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attr <= '0;
    end else if (cfg_we && cfg_addr == '0) begin
      attr <= cfg_wdata[ATTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_to_hub <= 1'b0;
      out_err    <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_to_hub <= to_hub;
      out_err    <= to_hub && req_iwb;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/legacy_window_router_chk.sv
module legacy_window_router_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_src,
  input logic              req_nosnoop,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_to_hub,
  input logic              out_err
);
  logic acc, outside, hi_range;
  assign acc      = req_valid && req_ready;
  assign outside  = (req_addr < ADDR_W'(32'h000C_0000)) || (req_addr >= ADDR_W'(32'h0010_0000));
  assign hi_range = (req_addr >= ADDR_W'(32'h000E_0000)) && (req_addr < ADDR_W'(32'h0010_0000));

  AST_OUTSIDE_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    acc && outside |=> !out_to_hub && !out_err); // R5
  AST_NOSNOOP_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    acc && hi_range && req_nosnoop && req_src != 2'd0 |=> !out_to_hub); // R6
  AST_ERR_NEEDS_HUB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_to_hub); // R7
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_to_hub) && $stable(out_err)); // R8
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready); // R8
endmodule

bind legacy_window_router legacy_window_router_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_src(req_src), .req_nosnoop(req_nosnoop),
  .out_valid(out_valid), .out_ready(out_ready), .out_to_hub(out_to_hub),
  .out_err(out_err)
);

// File: tb/tb_legacy_window_router.sv
module tb_legacy_window_router;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_nosnoop = 1'b0, req_iwb = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0] req_src = '0;
  logic out_ready = 1'b1;
  logic req_ready, out_valid, out_to_hub, out_err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_window_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_src(req_src), .req_nosnoop(req_nosnoop), .req_iwb(req_iwb),
    .out_valid(out_valid), .out_ready(out_ready), .out_to_hub(out_to_hub), .out_err(out_err)
  );

  // {req_tag[4], cfg[26], addr[24], write, src[2], nosnoop, iwb, exp_hub, exp_err}
  localparam logic [60:0] VEC [NV] = '{
    {4'd2, 26'h0000000, 24'h0C0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 read, RE off
    {4'd2, 26'h0000001, 24'h0C0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 read, RE on
    {4'd3, 26'h0000001, 24'h0C0000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 write, only RE on
    {4'd3, 26'h0000002, 24'h0C3FFF, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 write, WE on
    {4'd4, 26'h0000004, 24'h0C4000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 seg1
    {4'd4, 26'h0000004, 24'h0C0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 seg0 untouched
    {4'd4, 26'h0004000, 24'h0DC000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 seg7
    {4'd4, 26'h0010000, 24'h0E0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 seg8
    {4'd4, 26'h0400000, 24'h0EC000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 seg11
    {4'd4, 26'h1000000, 24'h0FFFFF, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 seg12 RE
    {4'd4, 26'h1000000, 24'h0F8000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 seg12 WE off
    {4'd4, 26'h2000000, 24'h0F0000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 seg12 WE
    {4'd5, 26'h0000000, 24'h0BFFFF, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 below window
    {4'd5, 26'h0000000, 24'h100000, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 above window
    {4'd6, 26'h0000000, 24'h0E4000, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 PCIe non-snooped
    {4'd6, 26'h0000000, 24'h0F0000, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 hub non-snooped
    {4'd6, 26'h0000000, 24'h0D0000, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 C/D range follows attrs
    {4'd6, 26'h0000000, 24'h0F0000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 processor follows attrs
    {4'd7, 26'h0000000, 24'h0F0000, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 snooped iwb to hub
    {4'd7, 26'h0000000, 24'h0C8000, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 processor iwb to hub
    {4'd7, 26'h3FFFFFF, 24'h0C8000, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 iwb to DRAM
    {4'd2, 26'h3FFFFFF, 24'h0FC000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}  // R2 all enabled
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {valid,hub,err} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive_req(input logic [31:0] a, input logic w, input logic [1:0] s,
                           input logic ns, input logic iwb);
    req_valid = 1'b1; req_addr = a; req_write = w; req_src = s;
    req_nosnoop = ns; req_iwb = iwb;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 reset outputs", {out_valid, req_ready, 1'b0}, 3'b010);
    drive_req(32'h000F_0000, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 F segment after reset", {out_valid, out_to_hub, out_err}, 3'b110);

    for (int i = 0; i < NV; i++) begin
      logic [60:0] v;
      string tag;
      v = VEC[i];
      cfg_write(4'd0, {6'd0, v[56:31]});
      drive_req({8'd0, v[30:7]}, v[6], v[5:4], v[3], v[2]);
      @(negedge clk);
      req_valid = 1'b0;
      tag = $sformatf("R%0d vector %0d", v[60:57], i);
      check(tag, {out_valid, out_to_hub, out_err}, {1'b1, v[1], v[0]});
    end

    // R10 write to a non-zero offset is ignored
    cfg_write(4'd0, 32'h0);
    cfg_write(4'd1, 32'hFFFF_FFFF);
    drive_req(32'h000C_0000, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 offset 1 ignored", {out_valid, out_to_hub, out_err}, 3'b110);

    // R9 write and request on the same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'h1;
    drive_req(32'h000C_0000, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 same-edge uses old attrs", {out_valid, out_to_hub, out_err}, 3'b110);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next edge uses new attrs", {out_valid, out_to_hub, out_err}, 3'b100);

    // R8 stall holds result and blocks acceptance
    @(negedge clk);
    out_ready = 1'b0;
    drive_req(32'h000C_0000, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 first result", {out_valid, out_to_hub, out_err}, 3'b100);
    check("R8 ready low while stalled", {req_ready, 2'b00}, 3'b000);
    drive_req(32'h000C_4000, 1'b0, 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 result held in stall", {out_valid, out_to_hub, out_err}, 3'b100);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 second request after drain", {out_valid, out_to_hub, out_err}, 3'b111);
    @(negedge clk);
    check("R8 valid drops when idle", {out_valid, 2'b00}, 3'b000);

    finish_run();
  end
endmodule